// File: doc/BRIEF.md
# Shared Serial Pin Multiplexer

This block lets a serial EEPROM controller and a buffered serial port take turns on one set of shared pads. Two pads carry the transmit clock and transmit data, one pad carries receive data, and a dedicated pad carries the EEPROM chip select. A bus-enable strap is captured during reset and then fixed. A port-select strap may move at any time after reset. While the bus is enabled, the EEPROM owns the pads after reset so that it can load configuration data. Once the configuration-done flag rises, a small on-chip sequencer raises a general-purpose control bit in steps, and that bit can be wired back to the port-select strap to hand the pads to the serial port.

A change of owner never lets two drivers meet on a pad. The port-select strap first passes through a synchroniser. All pad output-enables then drop for one clock, and only after that does the new owner drive. A separate clock-source pad belongs to the serial port unless its general-purpose function is enabled. Incoming pad data reaches only the peripheral that currently owns the pads. The peripheral that does not own them sees a constant 0.

Top module: `serial_pin_share`

## Requirements
- R1: The bus-enable strap is sampled on every clock edge while reset is asserted. After reset it is held, and later changes of the strap pin have no effect on pad ownership.
- R2: If the captured bus-enable is 1 and the port-select strap is 0, the EEPROM owns the pads after reset. The clock pad and data-out pad are enabled and carry the EEPROM clock and data-out, and the chip-select pad follows the EEPROM chip select.
- R3: While the serial port owns the pads, the clock pad and data-out pad are enabled and carry the port's transmit clock and transmit data, and the receive-data pad value goes to the port's receive input.
- R4: If the captured bus-enable is 0, the serial port owns the pads from reset onward, whatever the port-select strap does, and no gap cycle ever occurs.
- R5: A change of the port-select strap passes through SYNC_STAGES flip-flops (default 2). It then causes exactly one gap clock, in which both output-enables, both drive values and the chip select are 0, before the new owner drives. The owner never changes directly from EEPROM to serial port or back.
- R6: The chip-select pad is 0 whenever the EEPROM is not the owner.
- R7: The serial port's receive input is held at 0 unless the serial port owns the pads. The EEPROM data-in is held at 0 unless the EEPROM owns the pads. In the gap both are 0.
- R8: The clock-source pad is enabled and driven with the GPIO value when the GPIO enable is 1, and the serial port's clock-source input is then 0. When the GPIO enable is 0, the pad output-enable is 0 and the pad value reaches the serial port. Pad ownership has no effect on this pad.
- R9: After reset the sequencer keeps its control bit's enable, direction and value at 0 until the configuration-done flag is seen. On the following three clock edges it raises, in order, the enable, then the direction (output), then the value, and then it holds all three at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en_strap | input | 1 | Bus-enable strap, captured during reset |
| port_sel_strap | input | 1 | Port-select strap: 0 selects the EEPROM, 1 the serial port |
| cfg_done | input | 1 | Configuration-done flag from the EEPROM loader |
| ee_clk | input | 1 | EEPROM controller clock |
| ee_dout | input | 1 | EEPROM controller data toward the memory |
| ee_cs | input | 1 | EEPROM controller chip select, active high |
| ee_din | output | 1 | Data from the memory to the EEPROM controller |
| sp_tx_clk | input | 1 | Serial port transmit clock |
| sp_tx_dat | input | 1 | Serial port transmit data |
| sp_rx_dat | output | 1 | Receive data to the serial port |
| sp_clk_src | output | 1 | Clock source to the serial port |
| gpio_clk_en | input | 1 | GPIO function enable for the clock-source pad |
| gpio_clk_val | input | 1 | GPIO drive value for the clock-source pad |
| pad_clk_o | output | 1 | Shared clock pad drive value |
| pad_clk_oe | output | 1 | Shared clock pad output-enable |
| pad_txd_o | output | 1 | Shared data-out pad drive value |
| pad_txd_oe | output | 1 | Shared data-out pad output-enable |
| pad_rxd_i | input | 1 | Shared receive-data pad value |
| pad_cs_o | output | 1 | Dedicated chip-select pad drive value |
| pad_csrc_i | input | 1 | Clock-source pad input value |
| pad_csrc_o | output | 1 | Clock-source pad drive value |
| pad_csrc_oe | output | 1 | Clock-source pad output-enable |
| ctl_en | output | 1 | Sequencer control bit: function enable |
| ctl_oe | output | 1 | Sequencer control bit: output direction |
| ctl_val | output | 1 | Sequencer control bit: drive value |

## Verification
The bench targets the handover itself. It counts the edges from a strap change to the gap cycle and then to the new owner. A design that dropped the gap, or that counted the synchroniser wrongly, would show a cycle where both owners drive or where the gap falls one clock early or late. It toggles the bus-enable pin after reset to catch a design that keeps following the pin instead of the captured value. With the bus disabled it toggles the port-select strap to catch a spurious gap. It closes the loop from the sequencer's control bit back to the port-select strap and checks the step order, because a sequencer that raised the value before the direction would hand the pads over too early. Random data on every peripheral input checks that the receive path and the chip select stay quiet for the owner that is not selected.

// File: rtl/pinshare_pkg.sv
// Shared types for the serial pin multiplexer.
// Assumes: two-bit encodings suffice for both state machines.
package pinshare_pkg;

    typedef enum logic [1:0] {
        OWN_EE  = 2'd0,
        OWN_GAP = 2'd1,
        OWN_SP  = 2'd2
    } owner_e;

    typedef enum logic [1:0] {
        SEQ_WAIT   = 2'd0,
        SEQ_ENABLE = 2'd1,
        SEQ_DIR    = 2'd2,
        SEQ_DRIVE  = 2'd3
    } seq_e;

endpackage

// File: rtl/pinshare_sync.sv
// Multi-flop synchroniser for an asynchronous level input.
// Assumes: STAGES >= 1; reset value of every stage is 0.
module pinshare_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_chain
            // Purpose: shift the input through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pinshare_owner.sv
// Pad ownership state machine. Captures the bus-enable strap during reset
// and moves ownership between EEPROM and serial port through one gap clock.
// Assumes: sel_sync is already synchronised to clk.
module pinshare_owner
    import pinshare_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_strap,
    input  logic   sel_sync,
    output owner_e owner,
    output logic   bus_lat
);

    owner_e own_q;
    logic   want_sp;

    // Purpose: the serial port is wanted when the bus is off or it is selected.
    assign want_sp = !bus_lat || sel_sync;

    // Purpose: capture the strap in reset and step ownership through the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_lat <= bus_strap;
            own_q   <= bus_strap ? OWN_EE : OWN_SP;
        end else begin
            unique case (own_q)
                OWN_EE:  if (want_sp)  own_q <= OWN_GAP;
                OWN_SP:  if (!want_sp) own_q <= OWN_GAP;
                default: own_q <= want_sp ? OWN_SP : OWN_EE;
            endcase
        end
    end

    assign owner = own_q;

    // R1: captured strap never moves after reset
    a_r1_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(bus_lat));

    // R5: EEPROM ownership is never followed directly by serial port ownership
    a_r5_no_ee_to_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_EE) |=> (own_q != OWN_SP));

    // R5: serial port ownership is never followed directly by EEPROM ownership
    a_r5_no_sp_to_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q == OWN_SP) |=> (own_q != OWN_EE));

    // R4: bus disabled means the serial port always owns the pads
    a_r4_bus_off_sp: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_lat |-> (own_q == OWN_SP));

endmodule

// File: rtl/pinshare_seq.sv
// Switch-over sequencer: after the configuration-done flag it raises a
// general-purpose control bit in three ordered steps and then holds it.
// Assumes: cfg_done is synchronous to clk.
module pinshare_seq
    import pinshare_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    output logic ctl_en,
    output logic ctl_oe,
    output logic ctl_val
);

    seq_e st_q;

    // Purpose: advance one step per clock once configuration is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_WAIT;
        end else begin
            unique case (st_q)
                SEQ_WAIT:   if (cfg_done) st_q <= SEQ_ENABLE;
                SEQ_ENABLE: st_q <= SEQ_DIR;
                SEQ_DIR:    st_q <= SEQ_DRIVE;
                default:    st_q <= SEQ_DRIVE;
            endcase
        end
    end

    // Purpose: decode the control bit fields from the step.
    always_comb begin
        ctl_en  = (st_q != SEQ_WAIT);
        ctl_oe  = (st_q == SEQ_DIR) || (st_q == SEQ_DRIVE);
        ctl_val = (st_q == SEQ_DRIVE);
    end

    // R9: the value is only ever driven with the direction set
    a_r9_val_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_val |-> ctl_oe);

    // R9: direction rises only after enable was already up
    a_r9_dir_after_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_oe) |-> $past(ctl_en));

    // R9: value rises only after direction was already up
    a_r9_val_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_val) |-> $past(ctl_oe));

endmodule

// File: rtl/pinshare_route.sv
// Combinational pad routing for the current owner and the clock-source pad.
// Assumes: owner is a registered state; non-owners see constant 0.
module pinshare_route
    import pinshare_pkg::*;
(
    input  owner_e owner,
    input  logic   ee_clk,
    input  logic   ee_dout,
    input  logic   ee_cs,
    output logic   ee_din,
    input  logic   sp_tx_clk,
    input  logic   sp_tx_dat,
    output logic   sp_rx_dat,
    output logic   sp_clk_src,
    input  logic   gpio_clk_en,
    input  logic   gpio_clk_val,
    output logic   pad_clk_o,
    output logic   pad_clk_oe,
    output logic   pad_txd_o,
    output logic   pad_txd_oe,
    input  logic   pad_rxd_i,
    output logic   pad_cs_o,
    input  logic   pad_csrc_i,
    output logic   pad_csrc_o,
    output logic   pad_csrc_oe
);

    // Purpose: steer shared pads and return data by owner.
    always_comb begin
        pad_clk_o  = 1'b0;
        pad_clk_oe = 1'b0;
        pad_txd_o  = 1'b0;
        pad_txd_oe = 1'b0;
        pad_cs_o   = 1'b0;
        ee_din     = 1'b0;
        sp_rx_dat  = 1'b0;
        unique case (owner)
            OWN_EE: begin
                pad_clk_o  = ee_clk;
                pad_clk_oe = 1'b1;
                pad_txd_o  = ee_dout;
                pad_txd_oe = 1'b1;
                pad_cs_o   = ee_cs;
                ee_din     = pad_rxd_i;
            end
            OWN_SP: begin
                pad_clk_o  = sp_tx_clk;
                pad_clk_oe = 1'b1;
                pad_txd_o  = sp_tx_dat;
                pad_txd_oe = 1'b1;
                sp_rx_dat  = pad_rxd_i;
            end
            default: ;
        endcase
    end

    // Purpose: clock-source pad belongs to GPIO only when its enable is set.
    always_comb begin
        pad_csrc_oe = gpio_clk_en;
        pad_csrc_o  = gpio_clk_en ? gpio_clk_val : 1'b0;
        sp_clk_src  = gpio_clk_en ? 1'b0 : pad_csrc_i;
    end

endmodule

// File: rtl/serial_pin_share.sv
// Top of the shared serial pin multiplexer: synchroniser, ownership state
// machine, switch-over sequencer and pad router.
// Assumes: port_sel_strap is asynchronous; the other inputs are synchronous to clk.
module serial_pin_share
    import pinshare_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_en_strap,
    input  logic port_sel_strap,
    input  logic cfg_done,
    input  logic ee_clk,
    input  logic ee_dout,
    input  logic ee_cs,
    output logic ee_din,
    input  logic sp_tx_clk,
    input  logic sp_tx_dat,
    output logic sp_rx_dat,
    output logic sp_clk_src,
    input  logic gpio_clk_en,
    input  logic gpio_clk_val,
    output logic pad_clk_o,
    output logic pad_clk_oe,
    output logic pad_txd_o,
    output logic pad_txd_oe,
    input  logic pad_rxd_i,
    output logic pad_cs_o,
    input  logic pad_csrc_i,
    output logic pad_csrc_o,
    output logic pad_csrc_oe,
    output logic ctl_en,
    output logic ctl_oe,
    output logic ctl_val
);

    logic   sel_sync;
    logic   bus_lat;
    owner_e owner;

    pinshare_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (port_sel_strap),
        .q     (sel_sync)
    );

    pinshare_owner u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_strap (bus_en_strap),
        .sel_sync  (sel_sync),
        .owner     (owner),
        .bus_lat   (bus_lat)
    );

    pinshare_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_done (cfg_done),
        .ctl_en   (ctl_en),
        .ctl_oe   (ctl_oe),
        .ctl_val  (ctl_val)
    );

    pinshare_route u_route (
        .owner        (owner),
        .ee_clk       (ee_clk),
        .ee_dout      (ee_dout),
        .ee_cs        (ee_cs),
        .ee_din       (ee_din),
        .sp_tx_clk    (sp_tx_clk),
        .sp_tx_dat    (sp_tx_dat),
        .sp_rx_dat    (sp_rx_dat),
        .sp_clk_src   (sp_clk_src),
        .gpio_clk_en  (gpio_clk_en),
        .gpio_clk_val (gpio_clk_val),
        .pad_clk_o    (pad_clk_o),
        .pad_clk_oe   (pad_clk_oe),
        .pad_txd_o    (pad_txd_o),
        .pad_txd_oe   (pad_txd_oe),
        .pad_rxd_i    (pad_rxd_i),
        .pad_cs_o     (pad_cs_o),
        .pad_csrc_i   (pad_csrc_i),
        .pad_csrc_o   (pad_csrc_o),
        .pad_csrc_oe  (pad_csrc_oe)
    );

    // R6: a raised chip select is only seen while the EEPROM owns the pads
    a_r6_cs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        pad_cs_o |-> (owner == OWN_EE));

    // R7: serial receive data is quiet unless the serial port owns the pads
    a_r7_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sp_rx_dat |-> (owner == OWN_SP));

    // R7: EEPROM data-in is quiet unless the EEPROM owns the pads
    a_r7_ee_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ee_din |-> (owner == OWN_EE));

    // R5: after a gap clock both shared pads are driven again
    a_r5_gap_then_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_GAP) |=> (pad_clk_oe && pad_txd_oe));

endmodule

// File: tb/serial_pin_share_tb.sv
module serial_pin_share_tb;

    localparam int STAGES = 2;
    localparam int M_EE = 0, M_GAP = 1, M_SP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en_strap = 1'b1, sel_drv = 1'b0, use_loop = 1'b0, cfg_done = 1'b0;
    logic port_sel_strap;
    logic ee_clk = 0, ee_dout = 0, ee_cs = 0, sp_tx_clk = 0, sp_tx_dat = 0;
    logic gpio_clk_en = 0, gpio_clk_val = 0, pad_rxd_i = 0, pad_csrc_i = 0;
    logic ee_din, sp_rx_dat, sp_clk_src;
    logic pad_clk_o, pad_clk_oe, pad_txd_o, pad_txd_oe, pad_cs_o;
    logic pad_csrc_o, pad_csrc_oe, ctl_en, ctl_oe, ctl_val;
    int   total = 0, bad = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    assign port_sel_strap = use_loop ? (ctl_oe & ctl_val) : sel_drv;

    serial_pin_share #(.SYNC_STAGES(STAGES)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en_strap(bus_en_strap),
        .port_sel_strap(port_sel_strap), .cfg_done(cfg_done),
        .ee_clk(ee_clk), .ee_dout(ee_dout), .ee_cs(ee_cs), .ee_din(ee_din),
        .sp_tx_clk(sp_tx_clk), .sp_tx_dat(sp_tx_dat), .sp_rx_dat(sp_rx_dat),
        .sp_clk_src(sp_clk_src), .gpio_clk_en(gpio_clk_en), .gpio_clk_val(gpio_clk_val),
        .pad_clk_o(pad_clk_o), .pad_clk_oe(pad_clk_oe), .pad_txd_o(pad_txd_o),
        .pad_txd_oe(pad_txd_oe), .pad_rxd_i(pad_rxd_i), .pad_cs_o(pad_cs_o),
        .pad_csrc_i(pad_csrc_i), .pad_csrc_o(pad_csrc_o), .pad_csrc_oe(pad_csrc_oe),
        .ctl_en(ctl_en), .ctl_oe(ctl_oe), .ctl_val(ctl_val)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_pads(int mode);
        case (mode)
            M_EE:    return {1'b1, ee_clk, 1'b1, ee_dout, ee_cs, pad_rxd_i, 1'b0};
            M_SP:    return {1'b1, sp_tx_clk, 1'b1, sp_tx_dat, 1'b0, 1'b0, pad_rxd_i};
            default: return 7'b0;
        endcase
    endfunction

    function automatic logic [2:0] exp_csrc();
        return gpio_clk_en ? {1'b1, gpio_clk_val, 1'b0} : {1'b0, 1'b0, pad_csrc_i};
    endfunction

    task automatic check_pads(string req, int mode);
        #1;
        chk(req, {1'b0, pad_clk_oe, pad_clk_o, pad_txd_oe, pad_txd_o, pad_cs_o, ee_din, sp_rx_dat},
            {1'b0, exp_pads(mode)});
        chk("R8 clock-source pad", {5'b0, pad_csrc_oe, pad_csrc_o, sp_clk_src}, {5'b0, exp_csrc()});
    endtask

    task automatic rand_data();
        ee_clk = 1'($urandom); ee_dout = 1'($urandom); ee_cs = 1'($urandom);
        sp_tx_clk = 1'($urandom); sp_tx_dat = 1'($urandom); pad_rxd_i = 1'($urandom);
        gpio_clk_en = 1'($urandom); gpio_clk_val = 1'($urandom); pad_csrc_i = 1'($urandom);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic bus);
        @(negedge clk);
        rst_n = 1'b0; bus_en_strap = bus; sel_drv = 1'b0; use_loop = 1'b0; cfg_done = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_1234));

        // R2: EEPROM owns after reset with bus enabled
        do_reset(1'b1);
        check_pads("R2 reset owner EEPROM", M_EE);
        for (int i = 0; i < 20; i++) begin
            step(); rand_data();
            check_pads("R2/R7 EEPROM routing", M_EE);
        end

        // R1: later changes of the bus strap pin are ignored
        bus_en_strap = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(); rand_data();
            check_pads("R1 strap held", M_EE);
        end
        bus_en_strap = 1'b1;

        // R9: sequencer idles until configuration done
        for (int i = 0; i < 4; i++) begin
            step(); #1;
            chk("R9 idle", {5'b0, ctl_en, ctl_oe, ctl_val}, 8'b000);
        end
        use_loop = 1'b1;
        cfg_done = 1'b1;
        step(); #1; chk("R9 enable step", {5'b0, ctl_en, ctl_oe, ctl_val}, 8'b100);
        step(); #1; chk("R9 direction step", {5'b0, ctl_en, ctl_oe, ctl_val}, 8'b110);
        step(); #1; chk("R9 value step", {5'b0, ctl_en, ctl_oe, ctl_val}, 8'b111);

        // R5: handover to serial port after sync stages and one gap
        for (int i = 0; i < STAGES; i++) begin
            step(); rand_data();
            check_pads("R5 still EEPROM during sync", M_EE);
        end
        step(); rand_data();
        check_pads("R5/R6 gap clock", M_GAP);
        step();
        check_pads("R3 serial port after gap", M_SP);
        for (int i = 0; i < 20; i++) begin
            step(); rand_data();
            check_pads("R3/R7 serial routing", M_SP);
        end
        #1; chk("R9 hold", {5'b0, ctl_en, ctl_oe, ctl_val}, 8'b111);

        // R5: handover back to EEPROM
        use_loop = 1'b0; sel_drv = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            step(); rand_data();
            check_pads("R5 still serial during sync", M_SP);
        end
        step(); rand_data();
        check_pads("R5/R7 gap on return", M_GAP);
        step();
        check_pads("R5 EEPROM after gap", M_EE);

        // R4: bus disabled gives serial port regardless of select
        do_reset(1'b0);
        check_pads("R4 reset owner serial", M_SP);
        for (int i = 0; i < 20; i++) begin
            step(); rand_data(); sel_drv = 1'($urandom);
            check_pads("R4 select ignored", M_SP);
        end

        summary();
    end

endmodule